// File: doc/BRIEF.md
# Soft-Switch Memory Bank Mapper

This block sits on the CPU address bus of an 8-bit computer that has a 64K main RAM, a 64K auxiliary RAM and an internal ROM. Accesses to a handful of I/O locations in page $C0 act as soft switches. Each one sets or clears one of seven mode flags. For every CPU access, the block looks at the page (address bits 15:8) and the current flags. From these it drives a read-source select and a separate write-target select, so the read and write paths can be banked independently.

Status locations return one flag on data bit 7. All other data bits read as zero. The RAM and ROM arrays, video, peripheral cards and the upper $D000–$FFFF region sit outside the block and only consume the select outputs.

Both select outputs use one encoding: 0 = main RAM, 1 = aux RAM, 2 = internal ROM, 3 = slot ROM. Both selects are combinational from the address and the registered flags. A flag changes on the rising clock edge that ends a valid switch access, so the next access sees the new mapping.

Top module: `bank_mapper`

## Requirements
- R1: After reset all seven flags are clear. With the flags clear:
  - pages $00–$BF read from and write to main (code 0);
  - pages $C1–$CF, except $C3, read from slot ROM (code 3);
  - page $C3 reads from internal ROM (code 2).
- R2: A write to $C003 sets the read-aux flag and a write to $C002 clears it. While the flag is set, reads of pages $02–$BF select aux (code 1). The write path is not affected.
- R3: A write to $C005 sets the write-aux flag and a write to $C004 clears it. While the flag is set, writes to pages $02–$BF target aux (code 1). The read path is not affected.
- R4: A write to $C009 maps pages $00–$01 to aux on both paths, and a write to $C008 maps them back to main. The read-aux and write-aux flags have no effect on these pages.
- R5: A write to $C007 maps reads of pages $C1–$CF, except $C3, to internal ROM (code 2). A write to $C006 maps them to slot ROM (code 3).
- R6: A write to $C00B maps reads of page $C3 to slot ROM (code 3) and a write to $C00A maps them to internal ROM (code 2). This is independent of the R5 flag.
- R7: A read of a status location drives status_oe high and puts a flag on data bit 7, with bits 6:0 zero:
  - $C015 returns the internal-Cx flag;
  - $C016 returns the alternate zero-page flag;
  - $C017 returns the slot-C3 flag;
  - $C018 returns the text-store flag.
  On any other access status_oe is low and status_data is 0.
- R8: A write to $C001 sets the text-store flag and a write to $C000 clears it. Either a read or a write to $C055 sets the page-two flag, and either one to $C054 clears it. While the text-store flag is set, pages $04–$07 go to aux on both paths when page-two is set and to main when it is clear, overriding the read-aux and write-aux flags.
- R9: Flags change only on a clock edge with cpu_valid high. The selects during the switching access still reflect the old flags, and the next access sees the new ones. Accesses with cpu_valid low change nothing.
- R10: Reads of $C000–$C00B change no flag.
- R11: The following pages select main on both paths:
  - reads and writes of page $C0;
  - reads and writes of pages $D0–$FF;
  - writes to pages $C1–$CF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | A CPU access is present this cycle |
| cpu_read | input | 1 | 1 = read access, 0 = write access |
| cpu_addr | input | 16 | CPU address |
| rd_src | output | 2 | Read source for the addressed page (0 main, 1 aux, 2 internal ROM, 3 slot ROM) |
| wr_tgt | output | 2 | Write target for the addressed page (same encoding) |
| status_oe | output | 1 | Status location being read |
| status_data | output | 8 | Status byte, flag on bit 7 |

## Verification
The hardest situation to reach is the text-page override. It needs the text-store and page-two flags both set, combined with each setting of the read-aux and write-aux flags. It also needs page-two to be toggled by reads as well as by writes. The random stimulus draws half of its addresses from the switch and status locations, with both access directions and occasional idle cycles. The other half of the addresses fall on random pages. This walks the flag set through these combinations many times. Directed steps cover the reset map, the one-access delay of a switch, and idle or read accesses to write-only switches.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_IROM = 2'd2,
        SRC_SROM = 2'd3
    } src_e;

    typedef struct packed {
        logic store80;
        logic page2;
        logic rd_aux;
        logic wr_aux;
        logic alt_zp;
        logic int_cx;
        logic slot_c3;
    } flags_t;

    localparam logic [15:0] SW_STORE80_CLR = 16'hC000;
    localparam logic [15:0] SW_STORE80_SET = 16'hC001;
    localparam logic [15:0] SW_RDAUX_CLR   = 16'hC002;
    localparam logic [15:0] SW_RDAUX_SET   = 16'hC003;
    localparam logic [15:0] SW_WRAUX_CLR   = 16'hC004;
    localparam logic [15:0] SW_WRAUX_SET   = 16'hC005;
    localparam logic [15:0] SW_SLOTCX      = 16'hC006;
    localparam logic [15:0] SW_INTCX       = 16'hC007;
    localparam logic [15:0] SW_STDZP       = 16'hC008;
    localparam logic [15:0] SW_ALTZP       = 16'hC009;
    localparam logic [15:0] SW_INTC3       = 16'hC00A;
    localparam logic [15:0] SW_SLOTC3      = 16'hC00B;
    localparam logic [15:0] SW_PAGE2_CLR   = 16'hC054;
    localparam logic [15:0] SW_PAGE2_SET   = 16'hC055;
    localparam logic [15:0] ST_INTCX       = 16'hC015;
    localparam logic [15:0] ST_ALTZP       = 16'hC016;
    localparam logic [15:0] ST_SLOTC3      = 16'hC017;
    localparam logic [15:0] ST_STORE80     = 16'hC018;
endpackage

// File: rtl/switch_regs.sv
module switch_regs
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_read,
    input  logic [ADDR_W-1:0] acc_addr,
    output flags_t            flags_q
);
    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (acc_valid) begin
            if (!acc_read) begin
                case (acc_addr)
                    SW_STORE80_CLR: flags_d.store80 = 1'b0;
                    SW_STORE80_SET: flags_d.store80 = 1'b1;
                    SW_RDAUX_CLR:   flags_d.rd_aux  = 1'b0;
                    SW_RDAUX_SET:   flags_d.rd_aux  = 1'b1;
                    SW_WRAUX_CLR:   flags_d.wr_aux  = 1'b0;
                    SW_WRAUX_SET:   flags_d.wr_aux  = 1'b1;
                    SW_SLOTCX:      flags_d.int_cx  = 1'b0;
                    SW_INTCX:       flags_d.int_cx  = 1'b1;
                    SW_STDZP:       flags_d.alt_zp  = 1'b0;
                    SW_ALTZP:       flags_d.alt_zp  = 1'b1;
                    SW_INTC3:       flags_d.slot_c3 = 1'b0;
                    SW_SLOTC3:      flags_d.slot_c3 = 1'b1;
                    default: ;
                endcase
            end
            if (acc_addr == SW_PAGE2_CLR) flags_d.page2 = 1'b0;
            if (acc_addr == SW_PAGE2_SET) flags_d.page2 = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(flags_q));
    assert_rdaux_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_read && acc_addr == SW_RDAUX_SET) |=> flags_q.rd_aux);
    assert_page2_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr == SW_PAGE2_SET) |=> flags_q.page2);
    assert_read_no_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_read && acc_addr[15:4] == 12'hC00) |=> $stable(flags_q));
endmodule

// File: rtl/page_router.sv
module page_router
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  flags_t            flags,
    output src_e              rd_sel,
    output src_e              wr_sel
);
    localparam int PAGE_W = ADDR_W - 8;
    logic [PAGE_W-1:0] page;
    logic is_zp, is_text, is_gen, is_c3, is_cx;

    assign page    = acc_addr[ADDR_W-1 -: PAGE_W];
    assign is_zp   = page <= 8'h01;
    assign is_text = page >= 8'h04 && page <= 8'h07;
    assign is_gen  = page >= 8'h02 && page <= 8'hBF;
    assign is_c3   = page == 8'hC3;
    assign is_cx   = page >= 8'hC1 && page <= 8'hCF;

    always_comb begin
        rd_sel = SRC_MAIN;
        wr_sel = SRC_MAIN;
        if (is_zp) begin
            rd_sel = flags.alt_zp ? SRC_AUX : SRC_MAIN;
            wr_sel = rd_sel;
        end else if (is_text && flags.store80) begin
            rd_sel = flags.page2 ? SRC_AUX : SRC_MAIN;
            wr_sel = rd_sel;
        end else if (is_gen) begin
            rd_sel = flags.rd_aux ? SRC_AUX : SRC_MAIN;
            wr_sel = flags.wr_aux ? SRC_AUX : SRC_MAIN;
        end else if (is_c3) begin
            rd_sel = flags.slot_c3 ? SRC_SROM : SRC_IROM;
        end else if (is_cx) begin
            rd_sel = flags.int_cx ? SRC_IROM : SRC_SROM;
        end
    end

    assert_zp_paths_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_zp |-> rd_sel == wr_sel);
    assert_text_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_text && flags.store80 && flags.page2) |-> (rd_sel == SRC_AUX && wr_sel == SRC_AUX));
    assert_cx_is_rom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_cx |-> (rd_sel == SRC_IROM || rd_sel == SRC_SROM));
    assert_wr_is_ram_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel == SRC_MAIN || wr_sel == SRC_AUX);
endmodule

// File: rtl/status_mux.sv
module status_mux
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_read,
    input  logic [ADDR_W-1:0] acc_addr,
    input  flags_t            flags,
    output logic              st_oe,
    output logic [DATA_W-1:0] st_data
);
    logic bit_v;

    always_comb begin
        st_oe = acc_valid && acc_read;
        bit_v = 1'b0;
        case (acc_addr)
            ST_INTCX:   bit_v = flags.int_cx;
            ST_ALTZP:   bit_v = flags.alt_zp;
            ST_SLOTC3:  bit_v = flags.slot_c3;
            ST_STORE80: bit_v = flags.store80;
            default:    st_oe = 1'b0;
        endcase
        st_data = '0;
        if (st_oe) st_data[DATA_W-1] = bit_v;
    end

    assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_oe |-> st_data == '0);
    assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_data[DATA_W-2:0] == '0);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_read,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [1:0]        rd_src,
    output logic [1:0]        wr_tgt,
    output logic              status_oe,
    output logic [DATA_W-1:0] status_data
);
    flags_t flags_q;
    src_e   rd_sel, wr_sel;

    switch_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(cpu_valid), .acc_read(cpu_read),
        .acc_addr(cpu_addr), .flags_q(flags_q)
    );

    page_router #(.ADDR_W(ADDR_W)) u_router (
        .clk(clk), .rst_n(rst_n), .acc_addr(cpu_addr), .flags(flags_q),
        .rd_sel(rd_sel), .wr_sel(wr_sel)
    );

    status_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .acc_valid(cpu_valid), .acc_read(cpu_read),
        .acc_addr(cpu_addr), .flags(flags_q), .st_oe(status_oe), .st_data(status_data)
    );

    assign rd_src = rd_sel;
    assign wr_tgt = wr_sel;
endmodule

// File: tb/bank_mapper_bench.sv
`timescale 1ns/1ps
module bank_mapper_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0;
    logic cpu_read = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [1:0] rd_src, wr_tgt;
    logic status_oe;
    logic [7:0] status_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench copy of the flags, updated from the requirements
    bit m_s80, m_p2, m_rda, m_wra, m_azp, m_icx, m_sc3;

    always #2.5 clk = ~clk;

    bank_mapper u_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_read(cpu_read),
        .cpu_addr(cpu_addr), .rd_src(rd_src), .wr_tgt(wr_tgt),
        .status_oe(status_oe), .status_data(status_data)
    );

    function automatic logic [1:0] exp_rd(input logic [7:0] p);
        if (p <= 8'h01) return m_azp ? 2'd1 : 2'd0;
        if (p >= 8'h04 && p <= 8'h07 && m_s80) return m_p2 ? 2'd1 : 2'd0;
        if (p >= 8'h02 && p <= 8'hBF) return m_rda ? 2'd1 : 2'd0;
        if (p == 8'hC3) return m_sc3 ? 2'd3 : 2'd2;
        if (p >= 8'hC1 && p <= 8'hCF) return m_icx ? 2'd2 : 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [1:0] exp_wr(input logic [7:0] p);
        if (p <= 8'h01) return m_azp ? 2'd1 : 2'd0;
        if (p >= 8'h04 && p <= 8'h07 && m_s80) return m_p2 ? 2'd1 : 2'd0;
        if (p >= 8'h02 && p <= 8'hBF) return m_wra ? 2'd1 : 2'd0;
        return 2'd0;
    endfunction

    function automatic string tag_of(input logic [7:0] p);
        if (p <= 8'h01) return "R4";
        if (p >= 8'h04 && p <= 8'h07 && m_s80) return "R8";
        if (p >= 8'h02 && p <= 8'hBF) return "R2_R3";
        if (p == 8'hC3) return "R6";
        if (p >= 8'hC1 && p <= 8'hCF) return "R5";
        return "R11";
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_update(input logic [15:0] a, input bit rd, input bit v);
        if (!v) return;
        if (!rd) begin
            case (a)
                16'hC000: m_s80 = 0;  16'hC001: m_s80 = 1;
                16'hC002: m_rda = 0;  16'hC003: m_rda = 1;
                16'hC004: m_wra = 0;  16'hC005: m_wra = 1;
                16'hC006: m_icx = 0;  16'hC007: m_icx = 1;
                16'hC008: m_azp = 0;  16'hC009: m_azp = 1;
                16'hC00A: m_sc3 = 0;  16'hC00B: m_sc3 = 1;
                default: ;
            endcase
        end
        if (a == 16'hC054) m_p2 = 0;
        if (a == 16'hC055) m_p2 = 1;
    endtask

    // one access: drive at falling edge, sample 1 ns later, flags move at the next rising edge
    task automatic access(input logic [15:0] a, input bit rd, input bit v, input string req);
        logic eoe;
        logic [7:0] edat;
        @(negedge clk);
        cpu_addr = a; cpu_read = rd; cpu_valid = v;
        #1;
        check(req, {6'd0, rd_src}, {6'd0, exp_rd(a[15:8])}, "rd_src");
        check(req, {6'd0, wr_tgt}, {6'd0, exp_wr(a[15:8])}, "wr_tgt");
        eoe = 0; edat = 8'h00;
        if (v && rd) begin
            case (a)
                16'hC015: begin eoe = 1; edat = {m_icx, 7'd0}; end
                16'hC016: begin eoe = 1; edat = {m_azp, 7'd0}; end
                16'hC017: begin eoe = 1; edat = {m_sc3, 7'd0}; end
                16'hC018: begin eoe = 1; edat = {m_s80, 7'd0}; end
                default: ;
            endcase
        end
        check("R7", {7'd0, status_oe}, {7'd0, eoe}, "status_oe");
        check("R7", status_data, edat, "status_data");
        model_update(a, rd, v);
    endtask

    localparam int NSW = 18;
    function automatic logic [15:0] sw_addr(input int i);
        logic [15:0] t [NSW] = '{16'hC000, 16'hC001, 16'hC002, 16'hC003, 16'hC004, 16'hC005,
                                 16'hC006, 16'hC007, 16'hC008, 16'hC009, 16'hC00A, 16'hC00B,
                                 16'hC054, 16'hC055, 16'hC015, 16'hC016, 16'hC017, 16'hC018};
        return t[i];
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset map
        access(16'h0012, 1, 1, "R1");
        access(16'h2000, 0, 1, "R1");
        access(16'h0480, 1, 1, "R1");
        access(16'hC100, 1, 1, "R1");
        access(16'hC3FF, 1, 1, "R1");
        access(16'hC016, 1, 1, "R1");
        // R9: idle cycle changes nothing, valid switch takes effect on next access
        access(16'hC003, 0, 0, "R9");
        access(16'h3000, 1, 1, "R9");
        access(16'hC003, 0, 1, "R9");
        access(16'h3000, 1, 1, "R9");
        // R10: reading a write-only switch has no effect
        access(16'hC002, 1, 1, "R10");
        access(16'h3000, 1, 1, "R10");
        access(16'hC009, 1, 1, "R10");
        access(16'h0100, 0, 1, "R10");
        // R8: text-page override beats the aux flags, page-two toggled by a read
        access(16'hC002, 0, 1, "R8");
        access(16'hC001, 0, 1, "R8");
        access(16'hC055, 1, 1, "R8");
        access(16'h0500, 1, 1, "R8");
        access(16'h0700, 0, 1, "R8");
        access(16'hC005, 0, 1, "R8");
        access(16'hC054, 0, 1, "R8");
        access(16'h0600, 0, 1, "R8");
        access(16'hC018, 1, 1, "R8");
        // R6 independent of R5
        access(16'hC007, 0, 1, "R5");
        access(16'hC00B, 0, 1, "R6");
        access(16'hC300, 1, 1, "R6");
        access(16'hC400, 1, 1, "R5");
        access(16'hC017, 1, 1, "R6");
        // R11: upper region and I/O page
        access(16'hE000, 0, 1, "R11");
        access(16'hC0A0, 1, 1, "R11");
        access(16'hC500, 0, 1, "R11");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            bit rd, v;
            if ($urandom_range(1, 0) == 1) a = sw_addr($urandom_range(NSW - 1, 0));
            else a = 16'($urandom_range(16'hFFFF, 0));
            rd = $urandom_range(1, 0) == 1;
            v  = $urandom_range(9, 0) != 0;
            access(a, rd, v, tag_of(a[15:8]));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule